// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide internal form and turns it into a 32-bit IEEE-754 single-precision word. The internal form has a class code, a sign, a signed unbiased exponent, and a normalised mantissa. The mantissa's top bit is the integer one, and below it sit extra low-order bits that feed guard, round and sticky. A separate sticky flag covers bits that were discarded upstream.

The block adds the exponent bias and aligns the fraction. A result that is too small for a normal is shifted right into the subnormal range, and the bits pushed out join the sticky flag. The value is then rounded under one of four rounding modes. A subnormal that rounds up may become the smallest normal, and a normal whose significand rounds up to 2.0 bumps its exponent. An exponent that is too large saturates to infinity or to the largest finite value, depending on the mode and the sign.

NaN payloads pass through with the quiet bit forced on. Each accepted input gives one registered result, together with inexact, underflow and overflow flags, one cycle after it is accepted.

Top module: `sp_result_pack`

## Requirements
- R1: Class code 0 (zero) packs to the sign bit followed by 31 zero bits, with all flags clear, whatever the exponent, mantissa and sticky inputs hold.
- R2: Class code 2 (infinity) packs to the sign, exponent field 255 and a zero fraction, with all flags clear.
- R3: Class code 3 (NaN) packs to the sign and exponent field 255. Fraction bits 21:0 are mantissa bits MANT_W-3 down to MANT_W-24, and fraction bit 22 is forced to 1, so the output NaN is always quiet. All flags are clear.
- R4: For class code 1 (number), the biased exponent is the input exponent plus 127. The top 24 mantissa bits form the significand, and mantissa bit 27 holds the integer one at the default MANT_W of 28. Any nonzero discarded bit, or sticky_i, raises inexact. Mode code 0 rounds to nearest, and an exact tie goes to the even significand.
- R5: Mode code 1 truncates toward zero. Mode code 2 rounds an inexact value up in magnitude only when it is positive. Mode code 3 rounds an inexact value up in magnitude only when it is negative.
- R6: When rounding carries a normal significand to 2.0, the exponent field goes up by one and the fraction field becomes zero.
- R7: A biased exponent of 0 or below takes the subnormal path. The value is shifted right by one minus the biased exponent, the implicit one lands inside the fraction, and every bit shifted out joins sticky. The exponent field is 0. A result that becomes zero or stays subnormal and is inexact raises underflow.
- R8: An exact subnormal result raises underflow when uf_trap_en_i is 1, and raises no flag when uf_trap_en_i is 0.
- R9: A subnormal that rounds up to 2^23 packs as exponent field 1 with a zero fraction. It raises inexact but never underflow, even when uf_trap_en_i is 1.
- R10: A normal whose biased exponent after rounding is 255 or more raises both overflow and inexact. The result is signed infinity in mode 0, in mode 2 when positive, and in mode 3 when negative. In every other case it is the signed largest finite value, with exponent field 254 and an all-ones fraction.
- R11: After reset, every output is 0. valid_o is high exactly in the cycle after valid_i was high. Results and flags are registered only when valid_i is high, and otherwise hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value present this cycle |
| class_i | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W (10) | Unbiased exponent, two's complement |
| mant_i | input | MANT_W (28) | Normalised mantissa, integer one in the top bit |
| sticky_i | input | 1 | Upstream discarded bits were nonzero |
| rmode_i | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| uf_trap_en_i | input | 1 | Underflow trap enable |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Packed single-precision word |
| inexact_o | output | 1 | Result was rounded |
| underflow_o | output | 1 | Tiny result underflow |
| overflow_o | output | 1 | Exponent overflow |

## Verification
The block has a single register stage, so a wrong alignment, rounding decision or mode select shows up at result_o and the flags in the very cycle after the offending input. Nothing is held back to surface later. The vectors are aimed at the decision points where a slip changes the packed word by one unit, or moves it across a boundary. These are:
- the tie bit for even versus odd significands;
- the carry to 2.0;
- the last subnormal rounding up to the first normal;
- deep subnormals that collapse to zero or to the smallest subnormal;
- the largest finite value against overflow, in every mode and sign.

A corrupted hold path shows up as a result that changes while valid_i is low.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } val_class_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;

  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXPF_W  = 8;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = 255;
endpackage

// File: rtl/sp_align.sv
module sp_align
  import sp_pack_pkg::*;
#(
  parameter int MANT_W = 28,
  parameter int EXP_W  = 10,
  localparam int BE_W  = EXP_W + 2,
  localparam int SH_W  = $clog2(MANT_W + 1)
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    sticky_i,
  output logic [SIG_W-1:0]        kept_o,
  output logic                    guard_o,
  output logic                    round_o,
  output logic                    sticky_o,
  output logic signed [BE_W-1:0]  bexp_o,
  output logic                    tiny_o
);
  logic signed [BE_W-1:0] bexp;
  logic [BE_W-1:0]        sh_full;
  logic [SH_W-1:0]        sh;
  logic [MANT_W-1:0]      shifted;
  logic [MANT_W-1:0]      lost_mask;
  logic                   lost;

  always_comb begin
    bexp    = {{2{exp_i[EXP_W-1]}}, exp_i} + BE_W'(BIAS);
    tiny_o  = (bexp <= 0);
    sh_full = BE_W'(1) - bexp;
    if (!tiny_o)
      sh = '0;
    else if (sh_full >= BE_W'(MANT_W))
      sh = SH_W'(MANT_W);
    else
      sh = sh_full[SH_W-1:0];
    shifted   = mant_i >> sh;
    lost_mask = ~({MANT_W{1'b1}} << sh);
    lost      = |(mant_i & lost_mask);
  end

  assign bexp_o   = bexp;
  assign kept_o   = shifted[MANT_W-1 -: SIG_W];
  assign guard_o  = shifted[MANT_W-SIG_W-1];
  assign round_o  = shifted[MANT_W-SIG_W-2];
  assign sticky_o = (|shifted[MANT_W-SIG_W-3:0]) | lost | sticky_i;
endmodule

// File: rtl/sp_round.sv
module sp_round
  import sp_pack_pkg::*;
(
  input  logic [SIG_W-1:0] kept_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  rmode_e           rmode_i,
  output logic [SIG_W:0]   sum_o,
  output logic             inexact_o,
  output logic             to_inf_o
);
  logic up;

  always_comb begin
    inexact_o = guard_i | round_i | sticky_i;
    unique case (rmode_i)
      RM_NEAR_EVEN: begin
        up       = guard_i & (round_i | sticky_i | kept_i[0]);
        to_inf_o = 1'b1;
      end
      RM_TO_ZERO: begin
        up       = 1'b0;
        to_inf_o = 1'b0;
      end
      RM_UP: begin
        up       = inexact_o & ~sign_i;
        to_inf_o = ~sign_i;
      end
      default: begin
        up       = inexact_o & sign_i;
        to_inf_o = sign_i;
      end
    endcase
    sum_o = {1'b0, kept_i} + (SIG_W+1)'(up);
  end
endmodule

// File: rtl/sp_result_pack.sv
module sp_result_pack
  import sp_pack_pkg::*;
#(
  parameter int MANT_W = 28,
  parameter int EXP_W  = 10,
  localparam int BE_W  = EXP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        class_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        rmode_i,
  input  logic              uf_trap_en_i,
  output logic              valid_o,
  output logic [31:0]       result_o,
  output logic              inexact_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  logic [SIG_W-1:0]       kept;
  logic                   g_bit, r_bit, s_bit, tiny;
  logic signed [BE_W-1:0] bexp, exp_n;
  logic [SIG_W:0]         sum;
  logic                   nx, to_inf;
  logic [31:0]            res_d;
  logic                   nx_d, uf_d, of_d;

  sp_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i    (signed'(exp_i)),
    .mant_i   (mant_i),
    .sticky_i (sticky_i),
    .kept_o   (kept),
    .guard_o  (g_bit),
    .round_o  (r_bit),
    .sticky_o (s_bit),
    .bexp_o   (bexp),
    .tiny_o   (tiny)
  );

  sp_round u_round (
    .kept_i    (kept),
    .guard_i   (g_bit),
    .round_i   (r_bit),
    .sticky_i  (s_bit),
    .sign_i    (sign_i),
    .rmode_i   (rmode_e'(rmode_i)),
    .sum_o     (sum),
    .inexact_o (nx),
    .to_inf_o  (to_inf)
  );

  always_comb begin
    exp_n = bexp + BE_W'(sum[SIG_W]);
    res_d = {sign_i, 31'b0};
    nx_d  = 1'b0;
    uf_d  = 1'b0;
    of_d  = 1'b0;
    unique case (val_class_e'(class_i))
      CLS_ZERO: res_d = {sign_i, 31'b0};
      CLS_INF:  res_d = {sign_i, 8'hff, 23'b0};
      CLS_NAN:  res_d = {sign_i, 8'hff, 1'b1, mant_i[MANT_W-3 -: FRAC_W-1]};
      default: begin
        nx_d = nx;
        if (tiny) begin
          // sum[23] set means promotion to the smallest normal
          res_d = {sign_i, 7'b0, sum[FRAC_W], sum[FRAC_W-1:0]};
          uf_d  = ~sum[FRAC_W] & (nx | uf_trap_en_i);
        end else if (exp_n >= BE_W'(EXP_TOP)) begin
          of_d  = 1'b1;
          nx_d  = 1'b1;
          res_d = to_inf ? {sign_i, 8'hff, 23'b0} : {sign_i, 8'hfe, 23'h7fffff};
        end else begin
          res_d = {sign_i, exp_n[EXPF_W-1:0], sum[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= res_d;
        inexact_o   <= nx_d;
        underflow_o <= uf_d;
        overflow_o  <= of_d;
      end
    end
  end

  a_r11_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r11_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r1_zero_pack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == CLS_ZERO) |=> (result_o == {$past(sign_i), 31'b0}) && !inexact_o);
  a_r10_ovf_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> inexact_o && !underflow_o);
  a_r10_ovf_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> result_o[30:24] == 7'h7f);
  a_r8_uf_tiny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> result_o[30:23] == 8'h00);
  a_r3_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[30:23] == 8'hff && result_o[22:0] != 23'b0) |-> result_o[22]);
endmodule

// File: tb/sim_sp_result_pack.sv
module sim_sp_result_pack;
  localparam int MANT_W = 28;
  localparam int EXP_W  = 10;
  localparam int NV     = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] class_i = '0;
  logic sign_i = 1'b0;
  logic [EXP_W-1:0] exp_i = '0;
  logic [MANT_W-1:0] mant_i = '0;
  logic sticky_i = 1'b0;
  logic [1:0] rmode_i = '0;
  logic uf_trap_en_i = 1'b0;
  logic valid_o, inexact_o, underflow_o, overflow_o;
  logic [31:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sp_result_pack #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .class_i(class_i),
    .sign_i(sign_i), .exp_i(exp_i), .mant_i(mant_i), .sticky_i(sticky_i),
    .rmode_i(rmode_i), .uf_trap_en_i(uf_trap_en_i), .valid_o(valid_o),
    .result_o(result_o), .inexact_o(inexact_o), .underflow_o(underflow_o),
    .overflow_o(overflow_o)
  );

  // {class, sign, exp, mant, sticky, mode, trap, result, {nx,uf,of}}
  localparam logic [79:0] VEC [NV] = '{
    {2'd1, 1'b0, 10'sd0,    28'h8000000, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b000}, // R4
    {2'd1, 1'b1, 10'sd1,    28'hC000000, 1'b0, 2'd0, 1'b0, 32'hC0400000, 3'b000}, // R4
    {2'd1, 1'b0, 10'sd0,    28'h8000008, 1'b0, 2'd0, 1'b0, 32'h3F800000, 3'b100}, // R4 tie even
    {2'd1, 1'b0, 10'sd0,    28'h8000018, 1'b0, 2'd0, 1'b0, 32'h3F800002, 3'b100}, // R4 tie odd
    {2'd1, 1'b0, 10'sd0,    28'h800000C, 1'b0, 2'd0, 1'b0, 32'h3F800001, 3'b100}, // R4 above half
    {2'd1, 1'b0, 10'sd0,    28'h800001C, 1'b0, 2'd1, 1'b0, 32'h3F800001, 3'b100}, // R5
    {2'd1, 1'b1, 10'sd0,    28'h800001C, 1'b0, 2'd1, 1'b0, 32'hBF800001, 3'b100}, // R5
    {2'd1, 1'b0, 10'sd0,    28'h8000000, 1'b1, 2'd2, 1'b0, 32'h3F800001, 3'b100}, // R5
    {2'd1, 1'b1, 10'sd0,    28'h8000000, 1'b1, 2'd2, 1'b0, 32'hBF800000, 3'b100}, // R5
    {2'd1, 1'b1, 10'sd0,    28'h8000000, 1'b1, 2'd3, 1'b0, 32'hBF800001, 3'b100}, // R5
    {2'd1, 1'b0, 10'sd0,    28'hFFFFFF8, 1'b0, 2'd0, 1'b0, 32'h40000000, 3'b100}, // R6
    {2'd1, 1'b0, -10'sd127, 28'h8000000, 1'b0, 2'd0, 1'b0, 32'h00400000, 3'b000}, // R8
    {2'd1, 1'b0, -10'sd127, 28'h8000000, 1'b0, 2'd0, 1'b1, 32'h00400000, 3'b010}, // R8
    {2'd1, 1'b0, -10'sd127, 28'h8000010, 1'b0, 2'd0, 1'b0, 32'h00400000, 3'b110}, // R7
    {2'd1, 1'b0, -10'sd127, 28'hFFFFFFF, 1'b0, 2'd0, 1'b1, 32'h00800000, 3'b100}, // R9
    {2'd1, 1'b0, -10'sd200, 28'h8000000, 1'b0, 2'd0, 1'b0, 32'h00000000, 3'b110}, // R7
    {2'd1, 1'b0, -10'sd200, 28'h8000000, 1'b0, 2'd2, 1'b0, 32'h00000001, 3'b110}, // R7
    {2'd1, 1'b0, -10'sd149, 28'h8000000, 1'b0, 2'd0, 1'b0, 32'h00000001, 3'b000}, // R7
    {2'd1, 1'b0, 10'sd128,  28'h8000000, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b101}, // R10
    {2'd1, 1'b0, 10'sd128,  28'h8000000, 1'b0, 2'd1, 1'b0, 32'h7F7FFFFF, 3'b101}, // R10
    {2'd1, 1'b1, 10'sd128,  28'h8000000, 1'b0, 2'd2, 1'b0, 32'hFF7FFFFF, 3'b101}, // R10
    {2'd1, 1'b1, 10'sd128,  28'h8000000, 1'b0, 2'd3, 1'b0, 32'hFF800000, 3'b101}, // R10
    {2'd1, 1'b0, 10'sd127,  28'hFFFFFF8, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b101}, // R10
    {2'd1, 1'b0, 10'sd127,  28'hFFFFFF0, 1'b0, 2'd0, 1'b0, 32'h7F7FFFFF, 3'b000}, // R10
    {2'd0, 1'b1, 10'sd5,    28'hABCDEF0, 1'b1, 2'd2, 1'b1, 32'h80000000, 3'b000}, // R1
    {2'd2, 1'b0, 10'sd0,    28'h0000000, 1'b0, 2'd0, 1'b0, 32'h7F800000, 3'b000}, // R2
    {2'd2, 1'b1, 10'sd3,    28'h8000008, 1'b1, 2'd0, 1'b0, 32'hFF800000, 3'b000}, // R2
    {2'd3, 1'b0, 10'sd0,    28'h8000010, 1'b0, 2'd0, 1'b0, 32'h7FC00001, 3'b000}, // R3
    {2'd3, 1'b1, 10'sd0,    28'hABCDEF0, 1'b0, 2'd0, 1'b0, 32'hFFEBCDEF, 3'b000}  // R3
  };

  localparam int VREQ [NV] = '{4, 4, 4, 4, 4, 5, 5, 5, 5, 5, 6, 8, 8, 7, 9, 7, 7, 7,
                               10, 10, 10, 10, 10, 10, 1, 2, 2, 3, 3};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [79:0] v);
    class_i      = v[79:78];
    sign_i       = v[77];
    exp_i        = v[76:67];
    mant_i       = v[66:39];
    sticky_i     = v[38];
    rmode_i      = v[37:36];
    uf_trap_en_i = v[35];
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    valid_i = 1'b1;
    drive(VEC[0]);
    @(negedge clk);
    // R11 reset state while the input is active
    chk("R11 reset result", result_o, 32'h0);
    chk("R11 reset flags", {28'b0, valid_o, inexact_o, underflow_o, overflow_o}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      valid_i = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VREQ[i], i), result_o, VEC[i][34:3]);
      chk($sformatf("R%0d vec%0d flags", VREQ[i], i),
          {29'b0, inexact_o, underflow_o, overflow_o}, {29'b0, VEC[i][2:0]});
      chk($sformatf("R11 vec%0d valid", i), {31'b0, valid_o}, 32'h1);
    end
    // R11 hold: new inputs without valid leave result untouched
    drive(VEC[18]);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R11 idle valid", {31'b0, valid_o}, 32'h0);
    chk("R11 hold result", result_o, 32'hFFEBCDEF);
    chk("R11 hold flags", {29'b0, inexact_o, underflow_o, overflow_o}, 32'h0);
    // R9 promotion also in directed mode toward +inf with trap off
    drive({2'd1, 1'b0, -10'sd127, 28'hFFFFFF0, 1'b1, 2'd2, 1'b0, 32'h0, 3'b0});
    valid_i = 1'b1;
    @(negedge clk);
    chk("R9 promote rup", result_o, 32'h00800000);
    chk("R9 promote flags", {29'b0, inexact_o, underflow_o, overflow_o}, 32'h4);
    // R11 asynchronous reset mid-run clears outputs
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 async reset", {result_o[31:4], valid_o, inexact_o, underflow_o, overflow_o}, 32'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule